// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block turns a stream of per-word strobes from an audio receiver's bit-clock and word-length logic into frame timing. It counts word boundaries and divides them by a ratio taken from a 5-bit field. The ratio is always the field value plus one, so it ranges from 1 to 32. Each time the count returns to slot zero, the block emits a one-cycle frame sync pulse.

The mode bit selects how the ratio is used. In network mode the ratio is the number of time slots in a frame, and the block reports the current slot index. A field of zero in network mode has a special meaning: it selects on-demand operation, which has no periodic frame. In normal mode the ratio sets how often a word is transferred, and a transfer-enable output marks slot zero. A field of zero in normal mode gives a transfer on every word. That setting needs a one-bit-long sync, and any other sync length raises an error flag. Divider and mode changes take effect only at a frame boundary.

Top module: `afs_frame_sync_gen`

## Requirements
- R1: The divide ratio is the divider field plus one. In network mode with field F (1 to 31), `frame_sync_o` pulses once for every F+1 word strobes.
- R2: `slot_o` starts at 0 after reset. Each word strobe advances it by one. On the strobe that arrives at slot F, it returns to 0, and `frame_sync_o` is high for the one clock after that strobe, while `slot_o` reads 0.
- R3: In network mode with field 0, `on_demand_o` is 1, `slot_o` stays 0, and word strobes produce no frame sync.
- R4: In normal mode with field 0, every word strobe produces a frame sync and `xfer_en_o` stays 1 continuously.
- R5: `cfg_err_o` is 1 exactly when the active setting is normal mode with field 0 and `bit_sync_i` is 0 (sync longer than one bit). Otherwise it is 0.
- R6: In normal mode, `xfer_en_o` is 1 only while `slot_o` is 0, so word strobes in other slots are idle. In network mode, `xfer_en_o` is 0.
- R7: A change on `div_field_i` or `net_mode_i` is applied only on a word strobe that ends a frame (wraps to slot 0), or on any strobe while in on-demand operation. Until then the old ratio and mode keep governing the count.
- R8: While `rst_ni` is low on a clock edge, the slot is cleared to 0, frame sync is cleared, and the present divider and mode inputs become the active setting.
- R9: On a clock with no word strobe, `slot_o` holds its value and no frame sync is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| word_stb_i | input | 1 | One-clock strobe at each word boundary |
| div_field_i | input | 5 | Divider field; ratio is value plus one |
| net_mode_i | input | 1 | 1 = network mode, 0 = normal mode |
| bit_sync_i | input | 1 | 1 = sync one bit long, 0 = sync one word long |
| frame_sync_o | output | 1 | One-clock pulse when the count returns to slot 0 |
| slot_o | output | 5 | Current slot index |
| on_demand_o | output | 1 | Active setting is network mode with field 0 |
| xfer_en_o | output | 1 | Normal mode and current slot is 0 |
| cfg_err_o | output | 1 | Normal mode, field 0, sync not one bit long |

## Verification
The assertions take for granted that word strobes never arrive on two adjacent clocks. Real word boundaries are many system clocks apart, and the single-cycle frame-sync property depends on that spacing. They also take for granted that the divider and mode inputs are steady in the last reset cycle, because reset loads them directly. The stimulus drives each strobe for one clock followed by at least one idle clock, and it changes configuration only outside reset or while reset is held for several clocks.

// File: rtl/afs_pkg.sv
package afs_pkg;
    parameter int DIV_W = 5;

    typedef struct packed {
        logic             net;
        logic [DIV_W-1:0] ratio;
    } afs_cfg_t;
endpackage

// File: rtl/afs_slot_ctr.sv
module afs_slot_ctr #(
    parameter int W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         stb_i,
    input  logic [W-1:0] limit_i,
    input  logic         hold_i,
    output logic [W-1:0] slot_o,
    output logic         wrap_o,
    output logic         fs_o
);
    typedef struct packed {
        logic [W-1:0] slot;
        logic         fs;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic at_limit;

    always_comb begin
        ctr_d    = ctr_q;
        ctr_d.fs = 1'b0;
        at_limit = (ctr_q.slot == limit_i);
        wrap_o   = stb_i && !hold_i && at_limit;
        if (stb_i) begin
            if (hold_i) begin
                ctr_d.slot = '0;
            end else if (at_limit) begin
                ctr_d.slot = '0;
                ctr_d.fs   = 1'b1;
            end else begin
                ctr_d.slot = ctr_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign slot_o = ctr_q.slot;
    assign fs_o   = ctr_q.fs;
endmodule

// File: rtl/afs_mode_decode.sv
module afs_mode_decode
    import afs_pkg::*;
(
    input  afs_cfg_t         cfg_i,
    input  logic             bit_sync_i,
    input  logic [DIV_W-1:0] slot_i,
    output logic             on_demand_o,
    output logic             cfg_err_o,
    output logic             xfer_en_o
);
    logic ratio_one;

    always_comb begin
        ratio_one   = (cfg_i.ratio == '0);
        on_demand_o = cfg_i.net && ratio_one;
        cfg_err_o   = !cfg_i.net && ratio_one && !bit_sync_i;
        xfer_en_o   = !cfg_i.net && (slot_i == '0);
    end
endmodule

// File: rtl/afs_frame_sync_gen.sv
module afs_frame_sync_gen
    import afs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             word_stb_i,
    input  logic [DIV_W-1:0] div_field_i,
    input  logic             net_mode_i,
    input  logic             bit_sync_i,
    output logic             frame_sync_o,
    output logic [DIV_W-1:0] slot_o,
    output logic             on_demand_o,
    output logic             xfer_en_o,
    output logic             cfg_err_o
);
    afs_cfg_t cfg_d, cfg_q, cfg_in;
    logic     wrap;
    logic     boundary;

    afs_slot_ctr #(.W(DIV_W)) ctr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .stb_i   (word_stb_i),
        .limit_i (cfg_q.ratio),
        .hold_i  (on_demand_o),
        .slot_o  (slot_o),
        .wrap_o  (wrap),
        .fs_o    (frame_sync_o)
    );

    afs_mode_decode dec_i (
        .cfg_i       (cfg_q),
        .bit_sync_i  (bit_sync_i),
        .slot_i      (slot_o),
        .on_demand_o (on_demand_o),
        .cfg_err_o   (cfg_err_o),
        .xfer_en_o   (xfer_en_o)
    );

    always_comb begin
        cfg_in.net   = net_mode_i;
        cfg_in.ratio = div_field_i;
        boundary     = wrap || (word_stb_i && on_demand_o);
        cfg_d        = boundary ? cfg_in : cfg_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= cfg_in;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/afs_frame_sync_chk.sv
module afs_frame_sync_chk
    import afs_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             word_stb_i,
    input logic [DIV_W-1:0] slot_o,
    input logic             frame_sync_o,
    input logic             on_demand_o,
    input logic [DIV_W-1:0] act_ratio,
    input logic             act_net
);
    AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_o <= act_ratio); // R2
    AST_FS_AT_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_sync_o |-> (slot_o == '0)); // R2
    AST_FS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_sync_o |=> !frame_sync_o); // R2
    AST_OD_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        on_demand_o |-> (slot_o == '0)); // R3
    AST_OD_NO_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (on_demand_o && $past(on_demand_o) && $past(rst_ni)) |-> !frame_sync_o); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(word_stb_i)) |-> ($stable(slot_o) && !frame_sync_o)); // R9
    AST_CFG_AT_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !($stable(act_ratio) && $stable(act_net))) |-> $past(word_stb_i)); // R7
endmodule

bind afs_frame_sync_gen afs_frame_sync_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_stb_i   (word_stb_i),
    .slot_o       (slot_o),
    .frame_sync_o (frame_sync_o),
    .on_demand_o  (on_demand_o),
    .act_ratio    (cfg_q.ratio),
    .act_net      (cfg_q.net)
);

// File: tb/afs_frame_sync_gen_tb.sv
module afs_frame_sync_gen_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       word_stb_i = 1'b0;
    logic [4:0] div_field_i = 5'd0;
    logic       net_mode_i = 1'b1;
    logic       bit_sync_i = 1'b1;
    logic       frame_sync_o;
    logic [4:0] slot_o;
    logic       on_demand_o, xfer_en_o, cfg_err_o;

    int checks = 0;
    int failures = 0;
    int fs_seen;
    bit done = 0;

    always #5 clk_i = ~clk_i;

    afs_frame_sync_gen dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .word_stb_i(word_stb_i),
        .div_field_i(div_field_i), .net_mode_i(net_mode_i), .bit_sync_i(bit_sync_i),
        .frame_sync_o(frame_sync_o), .slot_o(slot_o), .on_demand_o(on_demand_o),
        .xfer_en_o(xfer_en_o), .cfg_err_o(cfg_err_o)
    );

    // net, field, bit_sync, strobes, expected frame syncs, expected final slot
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 5'd3,  1'b1, 6'd8,  6'd2, 5'd0},
        {1'b1, 5'd3,  1'b1, 6'd10, 6'd2, 5'd2},
        {1'b1, 5'd31, 1'b1, 6'd32, 6'd1, 5'd0},
        {1'b1, 5'd1,  1'b1, 6'd5,  6'd2, 5'd1},
        {1'b0, 5'd0,  1'b1, 6'd4,  6'd4, 5'd0},
        {1'b0, 5'd2,  1'b1, 6'd7,  6'd2, 5'd1},
        {1'b1, 5'd0,  1'b1, 6'd5,  6'd0, 5'd0},
        {1'b0, 5'd4,  1'b0, 6'd11, 6'd2, 5'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic net, input logic [4:0] fld, input logic bs);
        @(negedge clk_i);
        rst_ni = 1'b0; word_stb_i = 1'b0;
        net_mode_i = net; div_field_i = fld; bit_sync_i = bs;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    // one strobe, then one idle clock; counts frame syncs
    task automatic strobe();
        @(negedge clk_i);
        word_stb_i = 1'b1;
        @(posedge clk_i); #1;
        if (frame_sync_o) fs_seen++;
        @(negedge clk_i);
        word_stb_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R8 reset state
        do_reset(1'b1, 5'd3, 1'b1);
        #1;
        check("R8 slot after reset", slot_o, 0);
        check("R8 fs after reset", frame_sync_o, 0);

        // table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            do_reset(VEC[i][23], VEC[i][22:18], VEC[i][17]);
            fs_seen = 0;
            for (int k = 0; k < int'(VEC[i][16:11]); k++) strobe();
            #1;
            check("R1 frame sync count", fs_seen, VEC[i][10:5]);
            check("R2 final slot", slot_o, VEC[i][4:0]);
        end

        // R3 on-demand
        do_reset(1'b1, 5'd0, 1'b1);
        #1;
        check("R3 on_demand high", on_demand_o, 1);
        strobe(); #1;
        check("R3 slot held", slot_o, 0);
        do_reset(1'b1, 5'd2, 1'b1);
        #1;
        check("R3 on_demand low", on_demand_o, 0);

        // R5 error flag
        do_reset(1'b0, 5'd0, 1'b0);
        #1;
        check("R5 err word sync", cfg_err_o, 1);
        bit_sync_i = 1'b1; #1;
        check("R5 err bit sync", cfg_err_o, 0);
        do_reset(1'b1, 5'd0, 1'b0);
        #1;
        check("R5 err network", cfg_err_o, 0);
        do_reset(1'b0, 5'd3, 1'b0);
        #1;
        check("R5 err ratio>1", cfg_err_o, 0);

        // R4 continuous transfers
        do_reset(1'b0, 5'd0, 1'b1);
        fs_seen = 0;
        strobe(); strobe(); #1;
        check("R4 fs each word", fs_seen, 2);
        check("R4 xfer continuous", xfer_en_o, 1);

        // R6 transfer enable
        do_reset(1'b0, 5'd2, 1'b1);
        #1;
        check("R6 xfer slot0", xfer_en_o, 1);
        strobe(); #1;
        check("R6 xfer slot1", xfer_en_o, 0);
        do_reset(1'b1, 5'd2, 1'b1);
        #1;
        check("R6 xfer network", xfer_en_o, 0);

        // R7 deferred configuration
        do_reset(1'b1, 5'd3, 1'b1);
        fs_seen = 0;
        strobe();
        div_field_i = 5'd1; net_mode_i = 1'b1;
        strobe(); strobe(); #1;
        check("R7 old ratio slot", slot_o, 3);
        check("R7 no early fs", fs_seen, 0);
        strobe(); #1;
        check("R7 wrap old ratio", fs_seen, 1);
        strobe(); #1;
        check("R7 new ratio slot", slot_o, 1);
        strobe(); #1;
        check("R7 new ratio wrap", fs_seen, 2);
        net_mode_i = 1'b0;
        strobe(); #1;
        check("R7 mode kept mid-frame", xfer_en_o, 0);

        // R9 idle clocks
        repeat (5) @(negedge clk_i);
        check("R9 slot held", slot_o, 1);
        check("R9 no fs idle", frame_sync_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule